// File: doc/BRIEF.md
# DDR2 Mode Register Load Controller

This block sits between a memory controller front end and the DDR2 command path. It takes mode-register load requests, checks them, and decodes the 15-bit mode word into the fields the rest of the controller uses. The decoded fields are burst length, burst ordering, CAS latency, write recovery, test-mode select and power-down exit speed. A request counts as a mode-register write only when its bank-select code is zero. Such a write is accepted only when the bank tracker reports all banks idle, no burst is running, and the previous load's settle window has ended.

When a load is accepted, the block starts a settle counter. A lockout output stays high for `TMRD` cycles so that the front end issues no ACTIVE or other command in that window. The DLL-reset request in the word does not persist. It produces a single-cycle pulse, and every other field is held until the next good load or reset. A word that carries a reserved code in any decoded field is flagged, and the previously decoded settings stay in place.

Top module: `mrs_load_ctrl`

## Requirements
- R1: After reset the outputs are: burst length 4, sequential ordering, CAS latency 3, normal mode, write recovery 2, fast power-down exit, lockout low, and all pulse outputs low.
- R2: A request whose bank-select code is not 000 is ignored. No field changes and no pulse or error is raised.
- R3: A bank-0 request is rejected when banks_idle is low or burst_active is high. illegal_err then pulses for one cycle and no field changes.
- R4: Word bits [2:0] set the burst length: 010 gives 4 and 011 gives 8. Bit [3] sets the ordering: 0 is sequential and 1 is interleaved.
- R5: Word bits [6:4] set the CAS latency: 011, 100, 101 and 110 give 3, 4, 5 and 6.
- R6: Word bits [11:9] set the write recovery: 001 through 101 give 2 through 6.
- R7: Word bit [7] selects test mode when it is 1. Word bit [12] selects slow power-down exit when it is 1.
- R8: An accepted word with a reserved code in [2:0], [6:4] or [11:9] pulses reserved_err and keeps all previous fields. It still starts the lockout window.
- R9: An accepted load holds cmd_block high for exactly TMRD cycles, starting the cycle after acceptance. A bank-0 request during that window is rejected as in R3.
- R10: dll_reset_pulse is high for exactly one cycle after an accepted, non-reserved load whose bit [8] is 1. It is otherwise low.
- R11: Each good load replaces every field from the new word. No value from an earlier load survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| req_bank | input | 3 | Bank-select code of the request |
| req_word | input | 15 | Mode word |
| banks_idle | input | 1 | All banks precharged, from the bank tracker |
| burst_active | input | 1 | A read or write burst is running |
| cmd_block | output | 1 | Lockout: hold further commands |
| load_ok | output | 1 | Pulse: good load applied |
| illegal_err | output | 1 | Pulse: request rejected |
| reserved_err | output | 1 | Pulse: reserved code in the word |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| burst_len | output | 4 | Burst length (4 or 8) |
| burst_interleave | output | 1 | 1 = interleaved ordering |
| cas_lat | output | 3 | CAS latency in cycles |
| test_mode | output | 1 | 1 = test mode |
| wr_rec | output | 3 | Write recovery in cycles |
| pd_slow_exit | output | 1 | 1 = slow power-down exit |

## Verification
The assertions assume that req_valid is a one-cycle strobe driven between edges, and that banks_idle and burst_active are stable around each request. The rejection and field-retention properties rely on those inputs being clean when the request is sampled. The stimulus drives each request at a falling edge, holds it for a single cycle, and waits for the lockout to clear before the next table load. The only exception is the directed case that deliberately overlaps the lockout window.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int MODE_W = 15;
  localparam int BANK_W = 3;

  typedef struct packed {
    logic [3:0] bl;
    logic       bt;
    logic [2:0] cl;
    logic       tm;
    logic [2:0] wr;
    logic       pd;
  } mode_t;

  localparam mode_t RST_MODE = '{bl: 4'd4, bt: 1'b0, cl: 3'd3, tm: 1'b0, wr: 3'd2, pd: 1'b0};
endpackage

// File: rtl/mrs_decode.sv
module mrs_decode
  import mrs_pkg::*;
(
  input  logic [MODE_W-1:0] word,
  output mode_t             fields,
  output logic              reserved
);
  logic bl_bad, cl_bad, wr_bad;
  logic unused_hi;
  assign unused_hi = ^{word[14:13], word[8]};

  always_comb begin
    fields = RST_MODE;
    bl_bad = 1'b0;
    cl_bad = 1'b0;
    wr_bad = 1'b0;
    case (word[2:0])
      3'b010:  fields.bl = 4'd4;
      3'b011:  fields.bl = 4'd8;
      default: bl_bad = 1'b1;
    endcase
    fields.bt = word[3];
    case (word[6:4])
      3'b011:  fields.cl = 3'd3;
      3'b100:  fields.cl = 3'd4;
      3'b101:  fields.cl = 3'd5;
      3'b110:  fields.cl = 3'd6;
      default: cl_bad = 1'b1;
    endcase
    fields.tm = word[7];
    case (word[11:9])
      3'b001:  fields.wr = 3'd2;
      3'b010:  fields.wr = 3'd3;
      3'b011:  fields.wr = 3'd4;
      3'b100:  fields.wr = 3'd5;
      3'b101:  fields.wr = 3'd6;
      default: wr_bad = 1'b1;
    endcase
    fields.pd = word[12];
    reserved = bl_bad | cl_bad | wr_bad;
  end
endmodule

// File: rtl/mrs_gate.sv
module mrs_gate
  import mrs_pkg::*;
#(
  parameter int TMRD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              banks_idle,
  input  logic              burst_active,
  output logic              accept,
  output logic              reject,
  output logic              busy
);
  localparam int CNT_W = $clog2(TMRD + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TMRD);

  logic [CNT_W-1:0] cnt_q;
  logic             is_mr;

  assign is_mr  = req_valid && (req_bank == '0);
  assign busy   = (cnt_q != '0);
  assign accept = is_mr && banks_idle && !burst_active && !busy;
  assign reject = is_mr && !accept;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (accept) cnt_q <= CNT_LOAD;
    else if (busy)   cnt_q <= cnt_q - 1'b1;
  end

  // R9
  lock_start_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  // R9
  lock_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (is_mr && busy) |-> reject);
endmodule

// File: rtl/mrs_load_ctrl.sv
module mrs_load_ctrl
  import mrs_pkg::*;
#(
  parameter int TMRD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [MODE_W-1:0] req_word,
  input  logic              banks_idle,
  input  logic              burst_active,
  output logic              cmd_block,
  output logic              load_ok,
  output logic              illegal_err,
  output logic              reserved_err,
  output logic              dll_reset_pulse,
  output logic [3:0]        burst_len,
  output logic              burst_interleave,
  output logic [2:0]        cas_lat,
  output logic              test_mode,
  output logic [2:0]        wr_rec,
  output logic              pd_slow_exit
);
  mode_t dec_fields, mode_q;
  logic  dec_reserved, accept, reject;

  mrs_decode u_dec (
    .word     (req_word),
    .fields   (dec_fields),
    .reserved (dec_reserved)
  );

  mrs_gate #(.TMRD(TMRD)) u_gate (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_bank     (req_bank),
    .banks_idle   (banks_idle),
    .burst_active (burst_active),
    .accept       (accept),
    .reject       (reject),
    .busy         (cmd_block)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q          <= RST_MODE;
      load_ok         <= 1'b0;
      illegal_err     <= 1'b0;
      reserved_err    <= 1'b0;
      dll_reset_pulse <= 1'b0;
    end else begin
      load_ok         <= 1'b0;
      illegal_err     <= reject;
      reserved_err    <= 1'b0;
      dll_reset_pulse <= 1'b0;
      if (accept) begin
        if (dec_reserved) begin
          reserved_err <= 1'b1;
        end else begin
          mode_q          <= dec_fields;
          load_ok         <= 1'b1;
          dll_reset_pulse <= req_word[8];
        end
      end
    end
  end

  assign burst_len        = mode_q.bl;
  assign burst_interleave = mode_q.bt;
  assign cas_lat          = mode_q.cl;
  assign test_mode        = mode_q.tm;
  assign wr_rec           = mode_q.wr;
  assign pd_slow_exit     = mode_q.pd;

  // R10
  dll_single_chk: assert property (@(posedge clk) disable iff (rst)
    dll_reset_pulse |=> !dll_reset_pulse);
  // R3
  illegal_keep_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_err |-> $stable(mode_q));
  // R8
  reserved_keep_chk: assert property (@(posedge clk) disable iff (rst)
    reserved_err |-> ($stable(mode_q) && !load_ok));
  // R2
  bank_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bank != '0) |=> (!load_ok && !illegal_err && !reserved_err));
  // R3
  excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_ok && illegal_err));
endmodule

// File: tb/sim_mrs_load_ctrl.sv
module sim_mrs_load_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TMRD = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, banks_idle = 1, burst_active = 0;
  logic [2:0] req_bank = 0;
  logic [14:0] req_word = 0;
  logic cmd_block, load_ok, illegal_err, reserved_err, dll_reset_pulse;
  logic [3:0] burst_len;
  logic burst_interleave, test_mode, pd_slow_exit;
  logic [2:0] cas_lat, wr_rec;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrs_load_ctrl #(.TMRD(TMRD)) u0 (.*);

  // word layout: [12] pd, [11:9] wr, [8] dll, [7] tm, [6:4] cl, [3] bt, [2:0] bl
  function automatic logic [14:0] mk(input logic pd, input logic [2:0] wr, input logic dll,
                                     input logic tm, input logic [2:0] cl, input logic bt,
                                     input logic [2:0] bl);
    return {2'b00, pd, wr, dll, tm, cl, bt, bl};
  endfunction

  // entry: word, exp bl, bt, cl, tm, wr, pd, reserved
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {mk(0,3'b010,0,0,3'b100,0,3'b011), 4'd8, 1'b0, 3'd4, 1'b0, 3'd3, 1'b0, 1'b0},
    {mk(1,3'b011,0,1,3'b101,1,3'b010), 4'd4, 1'b1, 3'd5, 1'b1, 3'd4, 1'b1, 1'b0},
    {mk(0,3'b100,0,0,3'b110,1,3'b011), 4'd8, 1'b1, 3'd6, 1'b0, 3'd5, 1'b0, 1'b0},
    {mk(1,3'b101,0,0,3'b011,0,3'b010), 4'd4, 1'b0, 3'd3, 1'b0, 3'd6, 1'b1, 1'b0},
    {mk(0,3'b010,0,1,3'b100,1,3'b000), 4'd4, 1'b0, 3'd3, 1'b0, 3'd6, 1'b1, 1'b1},
    {mk(0,3'b010,0,1,3'b111,1,3'b011), 4'd4, 1'b0, 3'd3, 1'b0, 3'd6, 1'b1, 1'b1},
    {mk(0,3'b110,0,1,3'b100,1,3'b011), 4'd4, 1'b0, 3'd3, 1'b0, 3'd6, 1'b1, 1'b1},
    {mk(0,3'b001,0,1,3'b101,0,3'b011), 4'd8, 1'b0, 3'd5, 1'b1, 3'd2, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fields();
    return {burst_len, burst_interleave, cas_lat, test_mode, wr_rec, pd_slow_exit};
  endfunction

  // drive one request for one cycle; return sampled after the accepting edge
  task automatic issue(input logic [2:0] bank, input logic [14:0] w);
    @(negedge clk);
    req_valid = 1; req_bank = bank; req_word = w;
    @(negedge clk);
    req_valid = 0; req_bank = 0;
  endtask

  task automatic wait_free();
    while (cmd_block) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int snap, hi;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 bl", burst_len, 4);
    chk("R1 bt", burst_interleave, 0);
    chk("R1 cl", cas_lat, 3);
    chk("R1 tm", test_mode, 0);
    chk("R1 wr", wr_rec, 2);
    chk("R1 pd", pd_slow_exit, 0);
    chk("R1 pulses", {cmd_block, load_ok, illegal_err, reserved_err, dll_reset_pulse}, 0);

    // table walk: R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      issue(3'b000, VEC[i][28:14]);
      chk("R4 bl", burst_len, VEC[i][13:10]);
      chk("R4 bt", burst_interleave, VEC[i][9]);
      chk("R5 cl", cas_lat, VEC[i][8:6]);
      chk("R7 tm", test_mode, VEC[i][5]);
      chk("R6 wr", wr_rec, VEC[i][4:2]);
      chk("R7 pd", pd_slow_exit, VEC[i][1]);
      chk("R8 reserved_err", reserved_err, VEC[i][0]);
      chk("R11 load_ok", load_ok, !VEC[i][0]);
      chk("R8 lockout starts", cmd_block, 1);
      wait_free();
    end

    // R2 non-zero bank ignored
    snap = fields();
    issue(3'b010, mk(1,3'b011,1,1,3'b110,1,3'b010));
    chk("R2 fields", fields(), snap);
    chk("R2 pulses", {load_ok, illegal_err, reserved_err, dll_reset_pulse, cmd_block}, 0);

    // R3 banks not idle
    banks_idle = 0;
    issue(3'b000, mk(1,3'b011,0,0,3'b110,1,3'b010));
    chk("R3 idle err", illegal_err, 1);
    chk("R3 idle fields", fields(), snap);
    chk("R3 idle no lock", cmd_block, 0);
    banks_idle = 1;
    @(negedge clk);
    chk("R3 err one cycle", illegal_err, 0);

    // R3 burst in progress
    burst_active = 1;
    issue(3'b000, mk(1,3'b011,0,0,3'b110,1,3'b010));
    chk("R3 burst err", illegal_err, 1);
    chk("R3 burst fields", fields(), snap);
    burst_active = 0;

    // R10 DLL pulse and R9 lockout length
    issue(3'b000, mk(0,3'b011,1,0,3'b100,0,3'b010));
    chk("R10 dll high", dll_reset_pulse, 1);
    hi = 0;
    while (cmd_block && hi < 100) begin
      hi++;
      @(negedge clk);
      if (hi == 1) chk("R10 dll cleared", dll_reset_pulse, 0);
    end
    chk("R9 lockout cycles", hi, TMRD);

    // R9 load during lockout rejected
    issue(3'b000, mk(0,3'b011,0,0,3'b100,0,3'b011));
    snap = fields();
    issue(3'b000, mk(1,3'b101,0,1,3'b110,1,3'b010));
    chk("R9 busy reject", illegal_err, 1);
    chk("R9 busy fields", fields(), snap);
    wait_free();
    chk("R10 no dll", dll_reset_pulse, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule